// File: doc/BRIEF.md
# In-Order Store Queue with Load Forwarding

This block sits between one core's load/store port and its cache port. A store is taken into a small circular queue and acknowledged in the same cycle, so the core moves on without waiting for memory. While the queue holds anything, it offers the oldest entry to the cache's write port. Each time the cache accepts an entry, that entry is removed. As a result, stores reach the cache strictly in the order the core issued them.

Loads do not wait for older stores. A load drives the cache's read port combinationally and completes in the same cycle. If the load address equals the address of one or more queued stores, the block returns the data of the youngest of those stores instead of the cache value. Because of this, a load to a different location can complete before older stores become visible, which is total-store-order behaviour.

A fence request holds the core through a stall output until the cache has accepted every queued store. Accesses are word-sized and word-aligned, and forwarding matches on the full address only. The queue depth must be a power of two.

Top module: `store_queue`

## Requirements
- R1: `st_ready` is high whenever the queue holds fewer than DEPTH entries. A store presented with `st_valid` high while `st_ready` is high is accepted at that clock edge.
- R2: When the queue holds DEPTH entries, `st_ready` is low and a presented store is not taken. If a drain happens in the same cycle, it does not let a store in during that cycle.
- R3: `wr_valid` is high exactly when the queue is non-empty. `wr_addr` and `wr_data` always carry the oldest queued store, so stores reach the cache in issue order.
- R4: An entry leaves the queue only on a clock edge where both `wr_valid` and `wr_ready` are high. Until then, `wr_addr` and `wr_data` hold steady.
- R5: A load whose address matches no queued store returns `rd_data` in the same cycle, with `rd_addr` equal to `ld_addr`, and `ld_fwd` low.
- R6: A load whose address matches one or more queued stores returns the data of the youngest matching store in the same cycle, with `ld_fwd` high. A store accepted in that same cycle is not yet visible to the load.
- R7: `fence_stall` is high exactly when `fence_req` is high and the queue is non-empty. A fence issued with an empty queue does not stall.
- R8: After reset the queue is empty: `st_ready` is high, `wr_valid` is low and `fence_stall` is low.
- R9: A store accepted in the same cycle as a drain keeps the occupancy unchanged and is placed behind all older entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core presents a store |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core presents a load |
| ld_addr | input | AW | Load word address |
| ld_data | output | DW | Load result, same cycle |
| ld_fwd | output | 1 | Load result came from the queue |
| fence_req | input | 1 | Core requests a fence |
| fence_stall | output | 1 | Core must hold the fence |
| wr_valid | output | 1 | Oldest store offered to cache |
| wr_ready | input | 1 | Cache accepts the offered store |
| wr_addr | output | AW | Offered store address |
| wr_data | output | DW | Offered store data |
| rd_addr | output | AW | Cache read address |
| rd_data | input | DW | Cache read data, combinational |

## Verification
The bench builds the queue with DEPTH set to 4 and the 32-bit default widths, so the full condition is reached within a few stores. Pointer wrap-around then happens many times over a run. Addresses are drawn from only four words, which makes several queued stores to the same address common. This exercises youngest-entry selection across the wrap point. Cache readiness is throttled and withheld for long stretches, so queue-full stalls, pushes in the same cycle as drains, and fences waiting on a non-empty queue all occur repeatedly.

// File: rtl/store_queue_pkg.sv
package store_queue_pkg;

    // Queue occupancy change for one cycle
    typedef enum logic [1:0] {
        SQ_HOLD = 2'b00,
        SQ_PUSH = 2'b01,
        SQ_POP  = 2'b10,
        SQ_SWAP = 2'b11
    } sq_op_e;

endpackage

// File: rtl/sq_ptrs.sv
module sq_ptrs #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    import store_queue_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t p_d, p_q;
    sq_op_e     op;

    always_comb begin
        op  = sq_op_e'({pop, push});
        p_d = p_q;
        case (op)
            SQ_PUSH: begin
                p_d.tail = p_q.tail + 1'b1;
                p_d.cnt  = p_q.cnt + 1'b1;
            end
            SQ_POP: begin
                p_d.head = p_q.head + 1'b1;
                p_d.cnt  = p_q.cnt - 1'b1;
            end
            SQ_SWAP: begin
                p_d.head = p_q.head + 1'b1;
                p_d.tail = p_q.tail + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign head  = p_q.head;
    assign tail  = p_q.tail;
    assign full  = (p_q.cnt == CNT_W'(DEPTH));
    assign empty = (p_q.cnt == '0);

endmodule

// File: rtl/sq_forward.sv
module sq_forward #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         slot_vld,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0][DW-1:0] slot_data,
    input  logic [PTR_W-1:0]         head,
    input  logic [AW-1:0]            ld_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);
    // Per-slot compare done in parallel
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = slot_vld[g] && (slot_addr[g] == ld_addr);
    end

    // Walk from oldest to youngest; a later match overrides an earlier one
    always_comb begin
        logic [PTR_W-1:0] slot;
        hit      = 1'b0;
        hit_data = '0;
        for (int a = 0; a < DEPTH; a++) begin
            slot = head + PTR_W'(a);
            if (match[slot]) begin
                hit      = 1'b1;
                hit_data = slot_data[slot];
            end
        end
    end

endmodule

// File: rtl/store_queue.sv
module store_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic [DW-1:0] ld_data,
    output logic          ld_fwd,
    input  logic          fence_req,
    output logic          fence_stall,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
    } slot_state_t;

    slot_state_t      s_d, s_q;
    logic [PTR_W-1:0] head, tail;
    logic             full, empty, push, pop;
    logic             fwd_hit;
    logic [DW-1:0]    fwd_data;

    assign push = st_valid && !full;
    assign pop  = !empty && wr_ready;

    sq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .full  (full),
        .empty (empty)
    );

    always_comb begin
        s_d = s_q;
        if (pop) s_d.vld[head] = 1'b0;
        if (push) begin
            s_d.vld[tail]  = 1'b1;
            s_d.addr[tail] = st_addr;
            s_d.data[tail] = st_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    sq_forward #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .slot_vld  (s_q.vld),
        .slot_addr (s_q.addr),
        .slot_data (s_q.data),
        .head      (head),
        .ld_addr   (ld_addr),
        .hit       (fwd_hit),
        .hit_data  (fwd_data)
    );

    assign st_ready    = !full;
    assign wr_valid    = !empty;
    assign wr_addr     = s_q.addr[head];
    assign wr_data     = s_q.data[head];
    assign rd_addr     = ld_addr;
    assign ld_fwd      = ld_valid && fwd_hit;
    assign ld_data     = ld_fwd ? fwd_data : rd_data;
    assign fence_stall = fence_req && !empty;

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          fence_req,
    input logic          fence_stall
);
    // Occupancy rebuilt from the handshakes seen at the ports
    int occ;

    always_ff @(posedge clk) begin
        if (!rst_n) occ <= 0;
        else occ <= occ + ((st_valid && st_ready) ? 1 : 0)
                        - ((wr_valid && wr_ready) ? 1 : 0);
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == DEPTH) |-> !st_ready);

    assert_accept_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < DEPTH) |-> st_ready);

    assert_offer_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid == (occ != 0));

    assert_drain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_fence_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fence_stall == (fence_req && occ != 0));

endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .st_ready    (st_ready),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .fence_req   (fence_req),
    .fence_stall (fence_stall)
);

// File: tb/store_queue_test.sv
module store_queue_test;
    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, ld_valid = 1'b0, fence_req = 1'b0, wr_ready = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready, ld_fwd, fence_stall, wr_valid;
    logic [DW-1:0] ld_data, wr_data, rd_data;
    logic [AW-1:0] wr_addr, rd_addr;

    always #2 clk = ~clk;  // 250 MHz

    // Cache model: 16 words, combinational read
    logic [DW-1:0] mem [16];
    assign rd_data = mem[rd_addr[5:2]];

    store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data), .ld_fwd(ld_fwd),
        .fence_req(fence_req), .fence_stall(fence_stall),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Reference queue of pending stores, oldest first
    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance reference model
    task automatic cyc(input logic sv, input int sa, input logic [DW-1:0] sd,
                       input logic lv, input int la, input logic rdy, input logic fr);
        logic [DW-1:0] exp_ld;
        logic          exp_hit;
        logic          can_push;
        @(negedge clk);
        st_valid = sv; st_addr = AW'(sa * 4); st_data = sd;
        ld_valid = lv; ld_addr = AW'(la * 4);
        wr_ready = rdy; fence_req = fr;
        #1;
        chk("R1/R2 st_ready", 64'(st_ready), 64'(q_addr.size() < DEPTH));
        chk("R3 wr_valid", 64'(wr_valid), 64'(q_addr.size() != 0));
        if (q_addr.size() != 0) begin
            chk("R3 wr_addr oldest", 64'(wr_addr), 64'(q_addr[0]));
            chk("R3 wr_data oldest", 64'(wr_data), 64'(q_data[0]));
        end
        chk("R7 fence_stall", 64'(fence_stall), 64'(fr && q_addr.size() != 0));
        if (lv) begin
            exp_hit = 1'b0;
            exp_ld  = mem[la[3:0]];
            foreach (q_addr[i]) if (q_addr[i] == AW'(la * 4)) begin
                exp_hit = 1'b1;
                exp_ld  = q_data[i];
            end
            chk("R5 rd_addr", 64'(rd_addr), 64'(AW'(la * 4)));
            chk(exp_hit ? "R6 ld_fwd" : "R5 ld_fwd", 64'(ld_fwd), 64'(exp_hit));
            chk(exp_hit ? "R6 ld_data youngest" : "R5 ld_data cache", 64'(ld_data), 64'(exp_ld));
        end
        can_push = sv && (q_addr.size() < DEPTH);  // R9 order: push uses pre-drain occupancy
        if (rdy && q_addr.size() != 0) begin
            mem[q_addr[0][5:2]] = q_data[0];
            void'(q_addr.pop_front());
            void'(q_data.pop_front());
        end
        if (can_push) begin
            q_addr.push_back(AW'(sa * 4));
            q_data.push_back(sd);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 + DW'(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        fence_req = 1'b1;
        #1;
        // R8 reset state
        chk("R8 st_ready", 64'(st_ready), 64'd1);
        chk("R8 wr_valid", 64'(wr_valid), 64'd0);
        chk("R8 fence_stall", 64'(fence_stall), 64'd0);
        fence_req = 1'b0;
        rst_n = 1'b1;

        // R7: fence on empty queue does not stall
        cyc(0, 0, 0, 1, 2, 1, 1);
        // R1/R2/R6: fill with repeated address, cache stalled
        cyc(1, 1, 32'h1111_0001, 1, 1, 0, 0);
        cyc(1, 2, 32'h2222_0002, 1, 1, 0, 0);
        cyc(1, 1, 32'h1111_0003, 1, 1, 0, 1);
        cyc(1, 1, 32'h1111_0004, 1, 1, 0, 0);
        // R2: full, store refused, load sees youngest
        cyc(1, 3, 32'h3333_0005, 1, 1, 0, 0);
        cyc(1, 3, 32'h3333_0005, 1, 3, 0, 1);
        // R2/R9: drain while full, store still refused this cycle
        cyc(1, 3, 32'h3333_0006, 1, 2, 1, 0);
        // R9: push and drain together
        cyc(1, 0, 32'h0000_0007, 1, 3, 1, 1);
        // R4: hold with cache not ready
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 0, 0);
        // R7: fence waits for drain to finish
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, i % 4, 1, 1);

        // Mixed traffic over four words with throttled cache
        for (int n = 0; n < 3000; n++) begin
            logic rdy;
            rdy = ((n / 40) % 3 == 2) ? 1'b0 : ($urandom_range(0, 2) != 0);
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 3), DW'($urandom),
                $urandom_range(0, 1) == 1, $urandom_range(0, 3), rdy,
                $urandom_range(0, 3) == 0);
        end
        // Final drain
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 1, i % 4, 1, 1);
        summary();
    end

endmodule